// File: doc/BRIEF.md
# Probe Snapshot Edge Reporter

This block answers a host's request for an instant picture of every probe input. The host writes bytes into a byte-wide receive stream. When it sends the opcode byte 0x19 and then a count byte whose top bit is set and whose low seven bits equal the configured probe count, the block returns one byte per probe on a byte-wide transmit stream. The transmit stream waits for `tx_ready`.

Each reply byte carries three things: the probe's number, the probe's present level, and a flag for a rise or a fall. The flags are not measured against the previous clock. They compare the level now with the level that was reported in the previous snapshot. For this reason the block keeps a per-probe reference level, and it updates that reference only once the whole reply has gone out.

The probe count is a parameter. A value of 18 places the probe number in bits 7..3. A value of 8 places it in bits 7..4 and holds bit 3 at zero. Every probe input passes through a two-flop synchroniser before it is sampled.

Top module: `probe_snapshot_reporter`

## Requirements
- R1: The byte 0x19 followed by the byte (0x80 | NPROBE) (0x92 for 18 probes, 0x88 for 8) starts a reply of exactly NPROBE bytes, after which `tx_valid` goes low.
- R2: No reply is produced when the byte after 0x19 has bit 7 clear or a count other than NPROBE, or when a count byte arrives without a preceding 0x19. If that second byte is itself 0x19, it is taken as a fresh opcode.
- R3: Reply bytes go out in ascending probe order starting at probe 0. The probe number sits in bits 7..3 when NPROBE is 18. When NPROBE is 8 it sits in bits 7..4 and bit 3 is 0.
- R4: Bit 0 is the probe level sampled on the clock edge that accepts the count byte. That sample is taken after the two-flop synchroniser, so it holds the pin value from two edges earlier.
- R5: Bit 1 is set when the probe is high now and was low in the previous snapshot.
- R6: Bit 2 is set when the probe is low now and was high in the previous snapshot.
- R7: A probe that is unchanged since the previous snapshot has bits 2..1 equal to 0. Examples for probe 1 with NPROBE=8: a rise gives 0x13, steady high gives 0x11, a fall gives 0x14.
- R8: The reference levels are updated to the snapshot only after its last byte is accepted. After reset the reference levels are all low.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold steady.
- R10: Bytes received while a reply is in progress are discarded, and they do not change the snapshot being sent.
- R11: During reset `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Host byte present on `rx_byte` this cycle |
| rx_byte | input | 8 | Host command byte |
| probes | input | NPROBE | Asynchronous probe levels |
| tx_ready | input | 1 | Host accepts `tx_byte` this cycle |
| tx_valid | output | 1 | Reply byte available |
| tx_byte | output | 8 | Reply byte: probe number, fall flag, rise flag, level |

## Verification
A table of probe patterns is applied as a sequence of snapshots. The table covers all-low, all-high, repeated identical patterns, alternating bit patterns and their inverse, and single high bits at the lowest and highest probe. Comparing consecutive snapshots separates rise from fall from steady, and the single-bit patterns expose probe numbering or bit-order mistakes. Directed tests then cover malformed and restarted commands, a probe change on the same edge as the count byte (to show the synchroniser delay and the deferred reference update), a stalled transmit with a second command sent into the busy period, and the 8-probe byte layout.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam logic [7:0] SNAP_OPCODE = 8'h19;

  typedef enum logic {
    PS_WAIT_OP,
    PS_WAIT_CNT
  } parse_st_t;

  // Bit position of the probe number inside a reply byte.
  function automatic int id_lsb(input int nprobe);
    return (nprobe > 16) ? 3 : 4;
  endfunction
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/psr_parser.sv
module psr_parser
  import psr_pkg::*;
#(
  parameter int NPROBE = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       accept_en,
  output logic       cmd_fire
);
  localparam logic [7:0] CNT_BYTE = {1'b1, 7'(NPROBE)};

  parse_st_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cmd_fire = 1'b0;
    if (rx_valid && accept_en) begin
      unique case (state_q)
        PS_WAIT_OP: begin
          if (rx_byte == SNAP_OPCODE) state_d = PS_WAIT_CNT;
        end
        PS_WAIT_CNT: begin
          if (rx_byte == CNT_BYTE) begin
            cmd_fire = 1'b1;
            state_d  = PS_WAIT_OP;
          end else if (rx_byte == SNAP_OPCODE) begin
            state_d = PS_WAIT_CNT;
          end else begin
            state_d = PS_WAIT_OP;
          end
        end
        default: state_d = PS_WAIT_OP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_WAIT_OP;
    else        state_q <= state_d;
  end

  // R2
  fire_needs_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> (state_q == PS_WAIT_CNT) && rx_byte[7]);
endmodule

// File: rtl/psr_reply.sv
module psr_reply
  import psr_pkg::*;
#(
  parameter int NPROBE = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NPROBE-1:0] levels,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              busy
);
  localparam int IDX_W  = $clog2(NPROBE);
  localparam int ID_LSB = id_lsb(NPROBE);
  localparam int ID_W   = 8 - ID_LSB;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPROBE - 1);

  logic [NPROBE-1:0] snap_q, snap_d;
  logic [NPROBE-1:0] ref_q, ref_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              busy_q, busy_d;
  logic              snap_en, ref_en, idx_en;

  // Next-state logic with explicit clock enables.
  always_comb begin
    snap_d  = snap_q;
    ref_d   = ref_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    snap_en = 1'b0;
    ref_en  = 1'b0;
    idx_en  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        snap_d  = levels;
        snap_en = 1'b1;
        idx_d   = '0;
        idx_en  = 1'b1;
        busy_d  = 1'b1;
      end
    end else if (tx_ready) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        ref_d  = snap_q;
        ref_en = 1'b1;
      end else begin
        idx_d  = idx_q + 1'b1;
        idx_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      ref_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (snap_en) snap_q <= snap_d;
      if (ref_en)  ref_q  <= ref_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  logic       cur_lvl, prev_lvl;
  logic [2:0] flags;

  assign cur_lvl  = snap_q[idx_q];
  assign prev_lvl = ref_q[idx_q];
  assign flags    = {prev_lvl & ~cur_lvl, cur_lvl & ~prev_lvl, cur_lvl};

  generate
    if (ID_LSB == 3) begin : g_wide_layout
      assign tx_byte = {ID_W'(idx_q), flags};
    end else begin : g_narrow_layout
      assign tx_byte = {ID_W'(idx_q), 1'b0, flags};
    end
  endgenerate

  assign tx_valid = busy_q;
  assign busy     = busy_q;

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

  // R3
  first_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_byte[7:ID_LSB] == '0);

  // R3
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && (tx_byte[7:ID_LSB] != ID_W'(NPROBE - 1))
    |=> tx_valid && (tx_byte[7:ID_LSB] == $past(tx_byte[7:ID_LSB]) + 1'b1));

  // R1
  reply_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && (tx_byte[7:ID_LSB] == ID_W'(NPROBE - 1)) |=> !tx_valid);

  // R5 R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_byte[2] && tx_byte[1]));

  // R10
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(snap_q));
endmodule

// File: rtl/probe_snapshot_reporter.sv
module probe_snapshot_reporter #(
  parameter int NPROBE = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [NPROBE-1:0] probes,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NPROBE-1:0] lvl_sync;
  logic              cmd_fire;
  logic              busy;

  psr_sync #(.W(NPROBE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .async_in (probes),
    .sync_out (lvl_sync)
  );

  psr_parser #(.NPROBE(NPROBE)) u_parser (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .accept_en (!busy),
    .cmd_fire  (cmd_fire)
  );

  psr_reply #(.NPROBE(NPROBE)) u_reply (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start    (cmd_fire),
    .levels   (lvl_sync),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .busy     (busy)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !tx_valid);
endmodule

// File: tb/probe_snapshot_reporter_bench.sv
module probe_snapshot_reporter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic [17:0] probes;
  logic        tx_ready_w;
  logic        tx_valid_w, tx_valid_n;
  logic [7:0]  tx_byte_w, tx_byte_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0]  got_w [32];
  logic [7:0]  got_n [32];
  int          cnt_w, cnt_n;
  logic [17:0] ref_w;
  logic [7:0]  ref_n;

  localparam logic [17:0] VEC [10] = '{
    18'h00000, 18'h3FFFF, 18'h3FFFF, 18'h15555, 18'h2AAAA,
    18'h2AAAA, 18'h00001, 18'h20000, 18'h00000, 18'h0F0F0
  };

  always #4 clk = ~clk;

  probe_snapshot_reporter #(.NPROBE(18)) u_probe_snapshot_reporter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .probes(probes), .tx_ready(tx_ready_w),
    .tx_valid(tx_valid_w), .tx_byte(tx_byte_w)
  );

  probe_snapshot_reporter #(.NPROBE(8)) u_probe_snapshot_reporter_narrow (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .probes(probes[7:0]), .tx_ready(1'b1),
    .tx_valid(tx_valid_n), .tx_byte(tx_byte_n)
  );

  // Collectors sample 2 ns before each rising edge.
  always @(negedge clk) begin
    #2;
    if (tx_valid_w && tx_ready_w && cnt_w < 32) begin
      got_w[cnt_w] = tx_byte_w;
      cnt_w++;
    end
    if (tx_valid_n && cnt_n < 32) begin
      got_n[cnt_n] = tx_byte_n;
      cnt_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int id, input int lsb,
                                          input bit cur, input bit prv);
    logic [7:0] b;
    b = 8'(id << lsb);
    b[2] = prv & ~cur;
    b[1] = cur & ~prv;
    b[0] = cur;
    return b;
  endfunction

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_wide(input logic [17:0] lv, input string req);
    chk(cnt_w == 18, {req, " R1 byte count"}, cnt_w, 18);
    for (int i = 0; i < 18; i++)
      chk(got_w[i] == exp_byte(i, 3, lv[i], ref_w[i]), req, got_w[i],
          exp_byte(i, 3, lv[i], ref_w[i]));
    ref_w = lv;
  endtask

  task automatic check_narrow(input logic [7:0] lv, input string req);
    chk(cnt_n == 8, {req, " R1 narrow count"}, cnt_n, 8);
    for (int i = 0; i < 8; i++)
      chk(got_n[i] == exp_byte(i, 4, lv[i], ref_n[i]), req, got_n[i],
          exp_byte(i, 4, lv[i], ref_n[i]));
    ref_n = lv;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 50000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; probes = '0;
    tx_ready_w = 1'b1; cnt_w = 0; cnt_n = 0; ref_w = '0; ref_n = '0;
    idle(3);
    // R11: quiet during reset
    chk(tx_valid_w == 1'b0, "R11 wide", tx_valid_w, 0);
    chk(tx_valid_n == 1'b0, "R11 narrow", tx_valid_n, 0);
    rst_n = 1'b1;
    idle(5);

    // Vector table: R1 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 10; v++) begin
      probes = VEC[v];
      idle(4);
      cnt_w = 0;
      send(8'h19); send(8'h92);
      idle(30);
      check_wide(VEC[v], "R3/R5/R6/R7/R8 table");
    end

    // R2: malformed commands
    cnt_w = 0; cnt_n = 0;
    send(8'h19); send(8'h12); idle(30);
    chk(cnt_w == 0, "R2 bit7 clear", cnt_w, 0);
    send(8'h92); idle(30);
    chk(cnt_w == 0, "R2 no opcode", cnt_w, 0);
    chk(cnt_n == 0, "R2 narrow idle", cnt_n, 0);
    send(8'h19); send(8'h88); idle(30);
    chk(cnt_w == 0, "R2 wrong count", cnt_w, 0);
    check_narrow(probes[7:0], "R3 narrow layout");
    cnt_w = 0;
    send(8'h19); send(8'h19); send(8'h92); idle(30);
    check_wide(probes, "R2 restart");

    // R4: change on the edge of the count byte is not seen
    cnt_w = 0;
    send(8'h19);
    rx_valid = 1'b1; rx_byte = 8'h92; probes = 18'h3C3C3;
    @(negedge clk); rx_valid = 1'b0;
    idle(30);
    check_wide(ref_w, "R4 synchroniser delay");
    cnt_w = 0;
    send(8'h19); send(8'h92); idle(30);
    check_wide(18'h3C3C3, "R4/R8 deferred edge");

    // R9 R10: stall, and a command during the reply
    probes = 18'h00F0F; idle(4);
    tx_ready_w = 1'b0; cnt_w = 0;
    send(8'h19); send(8'h92);
    idle(3);
    chk(tx_valid_w == 1'b1, "R9 valid held", tx_valid_w, 1);
    chk(tx_byte_w == exp_byte(0, 3, 1'b1, ref_w[0]), "R9 byte held", tx_byte_w,
        exp_byte(0, 3, 1'b1, ref_w[0]));
    probes = 18'h3FFFF;
    send(8'h19); send(8'h92);
    idle(3);
    chk(cnt_w == 0, "R9 nothing taken", cnt_w, 0);
    tx_ready_w = 1'b1;
    idle(40);
    check_wide(18'h00F0F, "R10 busy discard");

    // R7 narrow: probe 1 rise, steady, fall
    probes = 18'h00002; idle(4); cnt_n = 0;
    send(8'h19); send(8'h88); idle(20);
    chk(got_n[1] == 8'h13, "R5 narrow rise", got_n[1], 8'h13);
    check_narrow(8'h02, "R5 narrow");
    cnt_n = 0;
    send(8'h19); send(8'h88); idle(20);
    chk(got_n[1] == 8'h11, "R7 narrow steady", got_n[1], 8'h11);
    probes = 18'h0; idle(4); cnt_n = 0;
    send(8'h19); send(8'h88); idle(20);
    chk(got_n[1] == 8'h14, "R6 narrow fall", got_n[1], 8'h14);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule